// File: doc/BRIEF.md
# ADC Conversion Frame Capture and Unpack

This block reads conversion results from a multi-channel delta-sigma ADC over SPI. It watches the converter's active-low data-ready line. On each falling edge it selects the converter and sends the read-data opcode, then clocks in one whole conversion frame. A frame is three status bytes followed by one sample for every channel the device has.

Once the frame is complete, the block releases chip select. It then emits one 32-bit word for each channel that the enable mask selects, lowest channel first, on a valid/ready stream. Each word carries the frame status, the channel index and a last-of-frame flag. The sample width depends on the rate code: the two fastest codes give 16-bit samples and every slower code gives 24-bit samples. Both widths come out in one format, a signed 24-bit value shifted left by 8 inside the word.

The rate code and the enable mask are taken once per frame, at the edge that starts it. A data-ready edge that arrives while a frame is still being captured or drained is dropped and recorded in a sticky flag.

Top module: `adc_frame_unpacker`

## Requirements
- R1: While reset is held and right after it, `spi_cs_n` is 1, `spi_sclk` is 0, `m_valid` is 0 and `overrun` is 0.
- R2: A falling edge on `drdy_n`, taken through a two-flop synchronizer, pulls `spi_cs_n` low and sends opcode 0x12 MSB first. SCLK idles low. The block changes MOSI on each rising SCLK edge and samples MISO on each falling edge.
- R3: After the opcode the block reads exactly 3 + B x NUM_CH bytes with MOSI held at 0, then raises `spi_cs_n`. B is 2 for rate codes 0 and 1 and 3 for every other code. The byte count is the same whatever the mask is. SCLK stays low while `spi_cs_n` is high, and no word is offered while `spi_cs_n` is low.
- R4: With rate code 2 or higher, each sample is 3 bytes, most significant byte first. `m_data` equals sample << 8, so `m_data[7:0]` is 0.
- R5: With rate code 0 or 1, each sample is 2 bytes, most significant byte first. `m_data` is {8 copies of sample bit 15, sample, 8'h00}.
- R6: Only channel i with `ch_enable[i]`=1 produces a word. Words come in ascending channel order, and `m_chan` gives the index of each.
- R7: `m_last` is 1 only on the final word of a frame. After that word is accepted, `m_valid` drops. A frame with an all-zero mask produces no words.
- R8: `m_status` holds the three status bytes. The first byte received is in bits [23:16].
- R9: While `m_valid`=1 and `m_ready`=0, `m_valid`, `m_data`, `m_chan`, `m_status` and `m_last` hold their values.
- R10: A data-ready falling edge during capture or drain sets `overrun` and starts no transaction. Once set, `overrun` stays set until reset.
- R11: Changes to `rate_code` or `ch_enable` after a frame has started have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| drdy_n | input | 1 | Converter data-ready, active low, asynchronous |
| rate_code | input | 3 | Rate code; values 0 and 1 select 16-bit samples |
| ch_enable | input | NUM_CH | Bit i enables output of channel i |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the converter |
| spi_miso | input | 1 | SPI data from the converter |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 32 | Sign-extended sample, left-aligned by 8 bits |
| m_chan | output | $clog2(NUM_CH) | Channel index of the word |
| m_status | output | 24 | Status bytes of the frame |
| m_last | output | 1 | Final word of the frame |
| overrun | output | 1 | Sticky: a data-ready edge was dropped |

## Verification
The properties assume that `drdy_n` holds each level for at least two clocks. They also assume that the converter changes MISO only in answer to a rising SCLK edge, so the bit is settled by the following falling edge. `m_ready` may behave in any way. The bench drives MISO from a converter model that updates on rising SCLK, and it holds data-ready low for several clocks per pulse. It switches `m_ready` between always-high, pseudo-random and held-low, which covers both the stall case and the back-to-back case. Edges that overlap a busy frame are produced on purpose only in the overrun cases.

// File: rtl/adc_frame_pkg.sv
// Package: constants, state encoding and the sample-to-word packing shared by
// the frame capture block. Assumes the rate code is 3 bits wide.
package adc_frame_pkg;

    localparam int         STATUS_BYTES   = 3;
    localparam logic [7:0] OPC_READ_FRAME = 8'h12;
    localparam int         RAW_W          = 24;
    localparam int         WORD_W         = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_DRAIN
    } seq_state_t;

    // Two fastest rate codes deliver 16-bit samples.
    function automatic logic is_narrow(input logic [2:0] code);
        return code < 3'd2;
    endfunction

    // Widen a raw sample to the 24-bit signed value shifted left by 8.
    function automatic logic [WORD_W-1:0] pack_word(input logic [RAW_W-1:0] raw,
                                                    input logic             narrow);
        if (narrow)
            return {{8{raw[15]}}, raw[15:0], 8'h00};
        return {raw, 8'h00};
    endfunction

endpackage

// File: rtl/afu_drdy_sync.sv
// Synchronizes the asynchronous active-low data-ready line and emits a
// one-cycle pulse on its falling edge. Assumes each level lasts >= 2 clocks.
module afu_drdy_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drdy_n,
    output logic fall_pulse
);

    logic [SYNC_STAGES:0] chain;

    // Shift the line through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain <= '1;
        else
            chain <= {chain[SYNC_STAGES-1:0], drdy_n};
    end

    assign fall_pulse = chain[SYNC_STAGES] & ~chain[SYNC_STAGES-1];

endmodule

// File: rtl/afu_spi_byte.sv
// Single-byte SPI transfer engine, SCLK idle low, launch on rising edge and
// sample on falling edge, MSB first. Assumes start only arrives while idle.
module afu_spi_byte #(
    parameter int HALF_PERIOD = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);

    localparam int TMR_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;

    logic             busy;
    logic [TMR_W-1:0] tmr;
    logic [2:0]       bit_cnt;
    logic [7:0]       tx_sh;
    logic [7:0]       rx_sh;

    // Half-period timer, SCLK toggling, bit launch and capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            tmr     <= '0;
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            sclk    <= 1'b0;
            mosi    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    tx_sh   <= tx_byte;
                    tmr     <= '0;
                    bit_cnt <= '0;
                end
            end else if (tmr == TMR_W'(HALF_PERIOD - 1)) begin
                tmr  <= '0;
                sclk <= ~sclk;
                if (!sclk) begin
                    mosi  <= tx_sh[7];
                    tx_sh <= {tx_sh[6:0], 1'b0};
                end else begin
                    rx_sh   <= {rx_sh[6:0], miso};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end
            end else begin
                tmr <= tmr + TMR_W'(1);
            end
        end
    end

    assign rx_byte = rx_sh;

endmodule

// File: rtl/afu_frame_collect.sv
// Sorts received frame bytes into the status word and per-channel raw
// samples (big-endian). Assumes clear is held between frames and the
// sample width is stable during a frame.
module afu_frame_collect
    import adc_frame_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear,
    input  logic                        narrow,
    input  logic                        byte_valid,
    input  logic [7:0]                  byte_in,
    output logic [23:0]                 status,
    output logic [NUM_CH-1:0][RAW_W-1:0] samples,
    output logic                        frame_end
);

    localparam int SC_W = $clog2(STATUS_BYTES + 1);

    logic [SC_W-1:0] stat_cnt;
    logic [1:0]      part;
    logic [CH_W-1:0] ch;
    logic [15:0]     acc;
    logic            in_status;
    logic            last_part;

    assign in_status = stat_cnt < SC_W'(STATUS_BYTES);
    assign last_part = narrow ? (part == 2'd1) : (part == 2'd2);
    assign frame_end = byte_valid && !in_status && last_part
                       && (ch == CH_W'(NUM_CH - 1));

    // Route each byte to status or to the current channel's accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_cnt <= '0;
            part     <= '0;
            ch       <= '0;
            acc      <= '0;
            status   <= '0;
            samples  <= '0;
        end else if (clear) begin
            stat_cnt <= '0;
            part     <= '0;
            ch       <= '0;
            acc      <= '0;
        end else if (byte_valid) begin
            if (in_status) begin
                status   <= {status[15:0], byte_in};
                stat_cnt <= stat_cnt + SC_W'(1);
            end else if (last_part) begin
                samples[ch] <= {acc, byte_in};
                acc         <= '0;
                part        <= '0;
                ch          <= ch + CH_W'(1);
            end else begin
                acc  <= {acc[7:0], byte_in};
                part <= part + 2'd1;
            end
        end
    end

endmodule

// File: rtl/afu_stream_out.sv
// Drains the captured samples of enabled channels, lowest index first, on a
// valid/ready stream. Assumes samples, status and width are stable while
// any channel is pending.
module afu_stream_out
    import adc_frame_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic [NUM_CH-1:0]            load_mask,
    input  logic                         narrow,
    input  logic [NUM_CH-1:0][RAW_W-1:0] samples,
    input  logic [23:0]                  status,
    input  logic                         m_ready,
    output logic                         m_valid,
    output logic [WORD_W-1:0]            m_data,
    output logic [CH_W-1:0]              m_chan,
    output logic [23:0]                  m_status,
    output logic                         m_last
);

    logic [NUM_CH-1:0] pend;
    logic [CH_W-1:0]   sel;

    // Lowest pending channel wins.
    always_comb begin
        sel = '0;
        for (int i = NUM_CH - 1; i >= 0; i--)
            if (pend[i]) sel = CH_W'(i);
    end

    // Load the mask at frame end; retire one channel per handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= '0;
        else if (load)
            pend <= load_mask;
        else if (m_valid && m_ready)
            pend[sel] <= 1'b0;
    end

    assign m_valid  = |pend;
    assign m_chan   = sel;
    assign m_data   = pack_word(samples[sel], narrow);
    assign m_status = status;
    assign m_last   = m_valid && ((pend & (pend - NUM_CH'(1))) == '0);

endmodule

// File: rtl/adc_frame_unpacker.sv
// Top: on a data-ready falling edge, reads one conversion frame over SPI
// (opcode, status, every channel's sample) and streams enabled channels out.
// Assumes NUM_CH is 4, 6 or 8 and the converter is ready to answer at the edge.
module adc_frame_unpacker
    import adc_frame_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int SCLK_HALF   = 2,
    parameter int SYNC_STAGES = 2,
    localparam int CH_W       = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drdy_n,
    input  logic [2:0]        rate_code,
    input  logic [NUM_CH-1:0] ch_enable,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [31:0]       m_data,
    output logic [CH_W-1:0]   m_chan,
    output logic [23:0]       m_status,
    output logic              m_last,
    output logic              overrun
);

    seq_state_t                  state;
    logic                        drdy_fall;
    logic                        start_q;
    logic [7:0]                  tx_q;
    logic                        narrow_q;
    logic [NUM_CH-1:0]           mask_q;
    logic                        byte_done;
    logic [7:0]                  rx_byte;
    logic                        frame_end;
    logic [23:0]                 status_w;
    logic [NUM_CH-1:0][RAW_W-1:0] samples_w;

    afu_drdy_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .drdy_n     (drdy_n),
        .fall_pulse (drdy_fall)
    );

    afu_spi_byte #(.HALF_PERIOD(SCLK_HALF)) u_spi (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_q),
        .tx_byte (tx_q),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .done    (byte_done),
        .rx_byte (rx_byte)
    );

    afu_frame_collect #(.NUM_CH(NUM_CH)) u_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (state == ST_IDLE),
        .narrow     (narrow_q),
        .byte_valid (byte_done && (state == ST_DATA)),
        .byte_in    (rx_byte),
        .status     (status_w),
        .samples    (samples_w),
        .frame_end  (frame_end)
    );

    afu_stream_out #(.NUM_CH(NUM_CH)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      ((state == ST_DATA) && frame_end),
        .load_mask (mask_q),
        .narrow    (narrow_q),
        .samples   (samples_w),
        .status    (status_w),
        .m_ready   (m_ready),
        .m_valid   (m_valid),
        .m_data    (m_data),
        .m_chan    (m_chan),
        .m_status  (m_status),
        .m_last    (m_last)
    );

    // Frame sequencer: select, opcode, frame bytes, drain; flags overlaps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            start_q  <= 1'b0;
            tx_q     <= '0;
            narrow_q <= 1'b0;
            mask_q   <= '0;
            spi_cs_n <= 1'b1;
            overrun  <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (drdy_fall && (state != ST_IDLE))
                overrun <= 1'b1;
            case (state)
                ST_IDLE: if (drdy_fall) begin
                    narrow_q <= is_narrow(rate_code);
                    mask_q   <= ch_enable;
                    spi_cs_n <= 1'b0;
                    tx_q     <= OPC_READ_FRAME;
                    start_q  <= 1'b1;
                    state    <= ST_CMD;
                end
                ST_CMD: if (byte_done) begin
                    tx_q    <= 8'h00;
                    start_q <= 1'b1;
                    state   <= ST_DATA;
                end
                ST_DATA: if (frame_end) begin
                    spi_cs_n <= 1'b1;
                    state    <= ST_DRAIN;
                end else if (byte_done) begin
                    start_q <= 1'b1;
                end
                ST_DRAIN: if (!m_valid)
                    state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/afu_checker.sv
// Property checker for the frame capture block, bound to its top module.
// Assumes drdy_n levels last >= 2 clocks and MISO settles before falling SCLK.
module afu_checker #(
    parameter int NUM_CH = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            spi_sclk,
    input logic            spi_cs_n,
    input logic            m_valid,
    input logic            m_ready,
    input logic [31:0]     m_data,
    input logic [CH_W-1:0] m_chan,
    input logic [23:0]     m_status,
    input logic            m_last,
    input logic            overrun
);

    // R9: a stalled word holds still
    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_chan)
                                && $stable(m_status) && $stable(m_last));

    // R3: clock only toggles while selected
    assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R3: no output while the frame is being clocked in
    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> !m_valid);

    // R4: low byte of every word is zero padding
    assert_pad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (m_data[7:0] == 8'h00));

    // R6: channels within a frame strictly ascend
    assert_ascending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && m_ready && !m_last |=> m_valid && (m_chan > $past(m_chan)));

    // R7: accepting the last word ends the stream of the frame
    assert_frame_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && m_ready && m_last |=> !m_valid);

    // R10: overrun is sticky
    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

bind adc_frame_unpacker afu_checker #(.NUM_CH(NUM_CH)) u_afu_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_sclk (spi_sclk),
    .spi_cs_n (spi_cs_n),
    .m_valid  (m_valid),
    .m_ready  (m_ready),
    .m_data   (m_data),
    .m_chan   (m_chan),
    .m_status (m_status),
    .m_last   (m_last),
    .overrun  (overrun)
);

// File: tb/test_adc_frame_unpacker.sv
// Scoreboard bench: a converter model answers on SPI, the driver queues
// expected words, a monitor compares each accepted word.
module test_adc_frame_unpacker;

    localparam int NCH = 8;
    localparam int CHW = $clog2(NCH);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           drdy_n = 1'b1;
    logic [2:0]     rate_code = 3'd6;
    logic [NCH-1:0] ch_enable = '1;
    logic           spi_miso = 1'b0;
    logic           m_ready = 1'b0;
    logic           spi_sclk, spi_cs_n, spi_mosi;
    logic           m_valid, m_last, overrun;
    logic [31:0]    m_data;
    logic [CHW-1:0] m_chan;
    logic [23:0]    m_status;

    always #2 clk = ~clk;

    adc_frame_unpacker #(.NUM_CH(NCH)) i_adc_frame_unpacker (
        .clk(clk), .rst_n(rst_n), .drdy_n(drdy_n), .rate_code(rate_code),
        .ch_enable(ch_enable), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .m_valid(m_valid),
        .m_ready(m_ready), .m_data(m_data), .m_chan(m_chan),
        .m_status(m_status), .m_last(m_last), .overrun(overrun)
    );

    typedef struct packed {
        logic [31:0]    data;
        logic [CHW-1:0] chan;
        logic [23:0]    status;
        logic           last;
        logic           narrow;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   n_words = 0;
    int   ready_mode = 0;
    logic [7:0] lfsr = 8'h5A;

    logic [7:0] fr [0:26];
    int   fr_len = 0;
    int   tx_bit = 0;
    int   rx_bit = 0;
    int   mosi_nz = 0;
    int   cs_falls = 0;
    bit   cs_armed = 0;
    logic [7:0] mosi_sh = '0;

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Converter model: select tracking
    initial forever begin
        @(negedge spi_cs_n);
        tx_bit = 0; rx_bit = 0; mosi_nz = 0;
        cs_falls++;
    end

    // Converter model: launch frame bits on rising SCLK
    initial forever begin
        @(posedge spi_sclk);
        if (spi_cs_n === 1'b0) begin
            int bi;
            bi = tx_bit - 8;
            if (bi >= 0 && bi < fr_len * 8)
                spi_miso = fr[bi / 8][7 - (bi % 8)];
            else
                spi_miso = 1'b0;
            tx_bit++;
        end
    end

    // Converter model: capture command bits on falling SCLK
    initial forever begin
        @(negedge spi_sclk);
        if (spi_cs_n === 1'b0) begin
            mosi_sh = {mosi_sh[6:0], spi_mosi};
            rx_bit++;
            if (rx_bit % 8 == 0) begin
                if (rx_bit == 8)
                    check(mosi_sh == 8'h12, "R2 opcode", 64'(mosi_sh), 64'h12);
                else if (mosi_sh != 8'h00)
                    mosi_nz++;
            end
        end
    end

    // Transaction length check at deselect
    initial forever begin
        @(posedge spi_cs_n);
        if (cs_armed && rst_n) begin
            check(rx_bit == 8 * (1 + fr_len), "R3 bits per transaction",
                  64'(rx_bit), 64'(8 * (1 + fr_len)));
            check(mosi_nz == 0, "R3 MOSI zero after opcode", 64'(mosi_nz), 64'h0);
        end
    end

    // Ready pattern driver
    initial forever begin
        @(negedge clk);
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        m_ready = (ready_mode == 0) || (ready_mode == 1 && lfsr[0]);
    end

    // Monitor: compare accepted words, check stall stability
    initial begin
        bit          prev_stall = 0;
        logic [31:0] prev_data = '0;
        logic [CHW-1:0] prev_chan = '0;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                if (prev_stall)
                    check(m_valid && m_data == prev_data && m_chan == prev_chan,
                          "R9 stalled word held", {31'(0), m_valid, m_data},
                          {31'(0), 1'b1, prev_data});
                prev_stall = m_valid && !m_ready;
                prev_data  = m_data;
                prev_chan  = m_chan;
                if (m_valid && m_ready) begin
                    n_words++;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R6 unexpected word", 64'(m_chan), 64'h0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(m_data == e.data, e.narrow ? "R5 narrow data" : "R4 wide data",
                              64'(m_data), 64'(e.data));
                        check(m_chan == e.chan, "R6 channel order", 64'(m_chan), 64'(e.chan));
                        check(m_status == e.status, "R8 status", 64'(m_status), 64'(e.status));
                        check(m_last == e.last, "R7 last flag", 64'(m_last), 64'(e.last));
                    end
                end
            end else begin
                prev_stall = 0;
            end
        end
    end

    // Driver: build a frame, queue expected words, pulse data-ready
    task automatic send_frame(input logic [2:0] rate, input logic [NCH-1:0] mask,
                              input logic [23:0] stat, input int seed, input bit scramble);
        int bps;
        int last_ch;
        int falls0;
        logic [23:0] raw;
        exp_t e;
        bps     = (rate < 3'd2) ? 2 : 3;
        fr_len  = 3 + bps * NCH;
        fr[0]   = stat[23:16];
        fr[1]   = stat[15:8];
        fr[2]   = stat[7:0];
        last_ch = -1;
        for (int c = 0; c < NCH; c++) if (mask[c]) last_ch = c;
        for (int c = 0; c < NCH; c++) begin
            raw = {8'(seed * 7 + c * 37), 8'(seed * 3 + c * 91), 8'(seed ^ (c * 13))};
            if (c == 1) raw = (bps == 2) ? 24'h008000 : 24'h800000;
            if (c == 2) raw = (bps == 2) ? 24'h007FFF : 24'h7FFFFF;
            if (bps == 2) begin
                fr[3 + 2 * c] = raw[15:8];
                fr[4 + 2 * c] = raw[7:0];
                e.data = {{8{raw[15]}}, raw[15:0], 8'h00};
            end else begin
                fr[3 + 3 * c] = raw[23:16];
                fr[4 + 3 * c] = raw[15:8];
                fr[5 + 3 * c] = raw[7:0];
                e.data = {raw, 8'h00};
            end
            e.chan   = CHW'(c);
            e.status = stat;
            e.last   = (c == last_ch);
            e.narrow = (bps == 2);
            if (mask[c]) exp_q.push_back(e);
        end
        falls0   = cs_falls;
        cs_armed = 1;
        @(negedge clk);
        rate_code = rate;
        ch_enable = mask;
        drdy_n    = 1'b0;
        while (cs_falls == falls0) @(negedge clk);
        if (scramble) begin
            rate_code = ~rate;
            ch_enable = ~mask;
        end
        repeat (2) @(negedge clk);
        drdy_n = 1'b1;
    endtask

    task automatic pulse_drdy();
        @(negedge clk);
        drdy_n = 1'b0;
        repeat (4) @(negedge clk);
        drdy_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_done();
        while (exp_q.size() != 0 || !spi_cs_n) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic check_reset_state(input string tag);
        check(spi_cs_n === 1'b1, {tag, " cs_n idle"}, 64'(spi_cs_n), 64'h1);
        check(spi_sclk === 1'b0, {tag, " sclk idle"}, 64'(spi_sclk), 64'h0);
        check(m_valid === 1'b0, {tag, " no word"}, 64'(m_valid), 64'h0);
        check(overrun === 1'b0, {tag, " overrun clear"}, 64'(overrun), 64'h0);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    // Main sequence
    initial begin
        int falls0;
        int words0;
        repeat (5) @(negedge clk);
        check_reset_state("R1 in reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_reset_state("R1 after reset");

        // R4: wide samples, all channels, always ready
        ready_mode = 0;
        send_frame(3'd6, 8'hFF, 24'hC0FFEE, 3, 0);
        wait_done();

        // R5: narrow samples at code 0, random ready
        ready_mode = 1;
        send_frame(3'd0, 8'hFF, 24'hA1B2C3, 11, 0);
        wait_done();

        // R5 / R6: narrow at code 1, sparse mask
        send_frame(3'd1, 8'b1010_0110, 24'h123456, 29, 0);
        wait_done();

        // R7: single highest channel, wide code 2
        send_frame(3'd2, 8'b1000_0000, 24'h00FF00, 41, 0);
        wait_done();

        // R7 / R3: empty mask still reads whole frame, yields nothing
        words0 = n_words;
        send_frame(3'd3, 8'h00, 24'h777777, 5, 0);
        wait_done();
        check(n_words == words0, "R7 empty mask gives no words", 64'(n_words - words0), 64'h0);

        // R11: inputs changed mid-frame do not affect it
        send_frame(3'd5, 8'h0F, 24'h5A5A5A, 17, 1);
        wait_done();
        check(overrun === 1'b0, "R10 no flag without overlap", 64'(overrun), 64'h0);

        // R10: edge during capture
        ready_mode = 0;
        falls0 = cs_falls;
        send_frame(3'd4, 8'h3C, 24'hBEEF01, 23, 0);
        pulse_drdy();
        wait_done();
        check(cs_falls == falls0 + 1, "R10 capture overlap starts nothing",
              64'(cs_falls - falls0), 64'h1);
        check(overrun === 1'b1, "R10 overrun after capture overlap", 64'(overrun), 64'h1);

        // R10: edge during drain with ready held low
        ready_mode = 2;
        falls0 = cs_falls;
        send_frame(3'd0, 8'h81, 24'h0BAD00, 37, 0);
        while (!m_valid) @(negedge clk);
        pulse_drdy();
        repeat (20) @(negedge clk);
        check(cs_falls == falls0 + 1 && spi_cs_n === 1'b1, "R10 drain overlap starts nothing",
              64'(cs_falls - falls0), 64'h1);
        check(overrun === 1'b1, "R10 overrun sticky", 64'(overrun), 64'h1);
        ready_mode = 0;
        wait_done();

        // R1: reset clears everything
        cs_armed = 0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_reset_state("R1 second reset");

        summary();
        $finish;
    end

endmodule